// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a watchdog for a small 8-bit controller. Software reaches it over a byte-wide register bus with an address, write data, a write strobe and a combinational read-data return. An 8-bit counter advances on a slow oscillator tick divided by a selectable power of two. When the counter runs past its top value, the block raises a one-cycle reset request and sets a sticky cause flag. Software keeps the request from firing by writing a refresh code to a refresh register, which restarts the count.

The control register is guarded. It can be written only right after a three-byte unlock code has been written to the key register, and that write access closes again on its own. A configuration pin can force the watchdog to run whatever the software enable bit says. The cause flag is not cleared by the restart that follows the watchdog's own request. Only a power-on reset, an external reset or a software write of 0 clears it, so software can find out why the chip was reset.

The unlock machine has four states. IDLE moves to ONE on a key write of 55h. ONE moves to TWO on a key write of AAh. TWO moves to OPEN on a key write of 5Ah. In ONE, TWO and OPEN, a key write of 55h goes to ONE, and any other bus write goes to IDLE. In IDLE, any bus write other than a key write of 55h stays in IDLE. While the machine is in OPEN, a control write is accepted. The oscillator tick `osc_tick` is a one-cycle enable that is already synchronous to `clk`.

Top module: `wdt_keyed`

## Requirements
- R1: After a power-on reset, the control register (address B6h) reads 04h, the key register (F7h) and the refresh register (B7h) read 00h, and `rst_req` is low.
- R2: A write to the control register is ignored unless the three key-register writes before it were 55h, AAh and 5Ah, in that order.
- R3: The unlock code must arrive with no other bus write in between. A wrong key byte aborts the code, and so does a write to any other address. A key write of 55h always counts as the first byte of a new code.
- R4: After the code, only the next bus write can use the open access. If that write goes to the control register it is accepted. Either way, later control writes are ignored until the code is written again.
- R5: In the control register, bit 7 is the cause flag, bit 5 is the software enable and bits 3:0 are the prescale select k. Bits 6 and 4 always read 0.
- R6: With the watchdog running and `osc_tick` high in every cycle, the counter steps once every 2^k cycles. `rst_req` first goes high 256·2^k cycles after the clock edge that took a refresh.
- R7: `rst_req` is high for exactly one cycle, and the count then starts again from zero.
- R8: A write of 55h to the refresh register while the watchdog is running restarts both the counter and the prescaler. A write of any other value to that register is ignored.
- R9: The watchdog runs when `cfg_en` is high or the enable bit is 1. While it is stopped, the counter and the prescaler hold their values and refresh writes have no effect.
- R10: The cause flag becomes 1 after `rst_req` and stays 1 through later restarts. An accepted control write with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it as it is.
- R11: A high `ext_rst` at a clock edge, or a low `por_n`, returns every part of the block to its reset state, the cause flag included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst | input | 1 | External reset, synchronous, active high |
| osc_tick | input | 1 | Slow-oscillator tick, one-cycle enable |
| cfg_en | input | 1 | Configuration pin that forces the watchdog to run |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | Reset request, one-cycle pulse |

## Verification
Register reads are combinational, so each read is sampled 1 ns after the address is applied at a falling edge. A write takes effect at the next rising edge, and its result is read at the falling edge that follows. `rst_req` comes from a register behind the counter. For each rising edge after a refresh, the bench samples it at the falling edge half a cycle later. The first high sample is expected at edge 256·2^k, or at an edge shifted by the refresh injected or the cycles spent stopped, and exactly one high sample is expected in the window. The cause flag is set one cycle after the pulse, so the bench reads it only after several more cycles.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
    localparam int BUS_W    = 8;
    localparam int FLAG_BIT = 7;
    localparam int EN_BIT   = 5;

    localparam logic [BUS_W-1:0] KEY_ADDR  = 8'hF7;
    localparam logic [BUS_W-1:0] CTRL_ADDR = 8'hB6;
    localparam logic [BUS_W-1:0] KICK_ADDR = 8'hB7;

    localparam logic [BUS_W-1:0] CODE_B0   = 8'h55;
    localparam logic [BUS_W-1:0] CODE_B1   = 8'hAA;
    localparam logic [BUS_W-1:0] CODE_B2   = 8'h5A;
    localparam logic [BUS_W-1:0] KICK_CODE = 8'h55;
    localparam logic [BUS_W-1:0] CTRL_INIT = 8'h04;

    typedef enum logic [1:0] {
        UL_IDLE,
        UL_ONE,
        UL_TWO,
        UL_OPEN
    } unlock_t;
endpackage

// File: rtl/wdt_unlock_fsm.sv
module wdt_unlock_fsm
    import wdt_keyed_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [BUS_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    output logic             wr_open
);
    unlock_t st, nxt;
    logic    key_wr, key_first;

    assign key_wr    = we && (addr == KEY_ADDR);
    assign key_first = key_wr && (wdata == CODE_B0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st <= UL_IDLE;
        else if (clr) st <= UL_IDLE;
        else          st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (we) begin
            unique case (st)
                UL_IDLE: nxt = key_first ? UL_ONE : UL_IDLE;
                UL_ONE:  nxt = (key_wr && wdata == CODE_B1) ? UL_TWO :
                               (key_first ? UL_ONE : UL_IDLE);
                UL_TWO:  nxt = (key_wr && wdata == CODE_B2) ? UL_OPEN :
                               (key_first ? UL_ONE : UL_IDLE);
                UL_OPEN: nxt = key_first ? UL_ONE : UL_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_open = (st == UL_OPEN);
    end

    AST_OPEN_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == UL_OPEN && we) |=> (st != UL_OPEN)); // R4
    AST_OPEN_AFTER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_open) |-> $past(key_wr && wdata == CODE_B2)); // R2
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             osc_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             pre_tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div, mask;

    assign mask     = (DIV_W'(1) << sel) - DIV_W'(1);
    assign pre_tick = run && osc_tick && ((div & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               div <= '0;
        else if (clr)             div <= '0;
        else if (run && osc_tick) div <= div + DIV_W'(1);
    end

    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(div)); // R9
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic ovf_pulse
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            ovf_pulse <= 1'b0;
        end else if (clr) begin
            cnt       <= '0;
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= step && (cnt == CNT_TOP);
            if (step) cnt <= cnt + CNT_W'(1);
        end
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse); // R7
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (cnt == '0)); // R7
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             ext_rst,
    input  logic             osc_tick,
    input  logic             cfg_en,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             bus_we,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             rst_req
);
    logic             wr_open, ctrl_wr, kick_ok, run, step, clr;
    logic             flag, en;
    logic [SEL_W-1:0] psel;
    logic [BUS_W-1:0] ctrl_view;
    logic             ctl_unused;

    assign ctl_unused = ^{bus_wdata[6], bus_wdata[4]};
    assign ctrl_wr    = bus_we && (bus_addr == CTRL_ADDR) && wr_open;
    assign run        = cfg_en || en;
    assign kick_ok    = bus_we && (bus_addr == KICK_ADDR) && (bus_wdata == KICK_CODE) && run;
    assign clr        = ext_rst || kick_ok;

    wdt_unlock_fsm u_lock (
        .clk(clk), .rst_n(por_n), .clr(ext_rst), .we(bus_we),
        .addr(bus_addr), .wdata(bus_wdata), .wr_open(wr_open)
    );

    wdt_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(por_n), .clr(clr), .run(run),
        .osc_tick(osc_tick), .sel(psel), .pre_tick(step)
    );

    wdt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(por_n), .clr(clr), .step(step), .ovf_pulse(rst_req)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag <= CTRL_INIT[FLAG_BIT];
            en   <= CTRL_INIT[EN_BIT];
            psel <= CTRL_INIT[SEL_W-1:0];
        end else if (ext_rst) begin
            flag <= CTRL_INIT[FLAG_BIT];
            en   <= CTRL_INIT[EN_BIT];
            psel <= CTRL_INIT[SEL_W-1:0];
        end else begin
            if (ctrl_wr) begin
                en   <= bus_wdata[EN_BIT];
                psel <= bus_wdata[SEL_W-1:0];
                if (!bus_wdata[FLAG_BIT]) flag <= 1'b0;
            end
            if (rst_req) flag <= 1'b1;
        end
    end

    always_comb begin
        ctrl_view              = '0;
        ctrl_view[FLAG_BIT]    = flag;
        ctrl_view[EN_BIT]      = en;
        ctrl_view[SEL_W-1:0]   = psel;
        bus_rdata              = (bus_addr == CTRL_ADDR) ? ctrl_view : '0;
    end

    AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (!por_n)
        (bus_we && bus_addr == CTRL_ADDR && !wr_open && !ext_rst && !rst_req)
        |=> $stable(ctrl_view)); // R2
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!por_n)
        (rst_req && !ext_rst) |=> flag); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (flag && !ext_rst && !ctrl_wr) |=> flag); // R10
    AST_EXT_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        ext_rst |=> (!flag && !rst_req)); // R11
endmodule

// File: tb/sim_wdt_keyed.sv
`timescale 1ns/1ps
module sim_wdt_keyed;
    logic       clk = 1'b0;
    logic       por_n, ext_rst, osc_tick, cfg_en, bus_we, rst_req;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    int         total = 0, bad = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    wdt_keyed u0 (
        .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .osc_tick(osc_tick),
        .cfg_en(cfg_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic unlock();
        wr(8'hF7, 8'h55); wr(8'hF7, 8'hAA); wr(8'hF7, 8'h5A);
    endtask

    task automatic idle(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            if (rst_req) highs++;
        end
    endtask

    // Refresh at edge 0, optional injected refresh-register write at edge inj
    task automatic window(input int inj, input logic [7:0] d, input int limit,
                          output int first, output int highs);
        first = 0; highs = 0;
        wr(8'hB7, 8'h55);
        for (int i = 1; i <= limit; i++) begin
            if (i == inj) begin bus_addr = 8'hB7; bus_wdata = d; bus_we = 1'b1; end
            @(posedge clk); @(negedge clk);
            bus_we = 1'b0;
            if (rst_req) begin highs++; if (first == 0) first = i; end
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'hB6, v); chk("R1 ctrl reset", v, 8'h04);
        rd(8'hF7, v); chk("R1 key reads 0", v, 8'h00);
        rd(8'hB7, v); chk("R1 kick reads 0", v, 8'h00);
        chk("R1 rst_req low", rst_req, 0);
    endtask

    task automatic t_locked();
        logic [7:0] v;
        wr(8'hB6, 8'h01); rd(8'hB6, v); chk("R2 locked write ignored", v, 8'h04);
        unlock(); wr(8'hB6, 8'h01); rd(8'hB6, v); chk("R2 unlocked write taken", v, 8'h01);
    endtask

    task automatic t_seq();
        logic [7:0] v;
        wr(8'hF7, 8'h55); wr(8'hF7, 8'h12); wr(8'hF7, 8'hAA); wr(8'hF7, 8'h5A);
        wr(8'hB6, 8'h05); rd(8'hB6, v); chk("R3 wrong byte aborts", v, 8'h01);
        wr(8'hF7, 8'h55); wr(8'hF7, 8'hAA); wr(8'hB7, 8'h00); wr(8'hF7, 8'h5A);
        wr(8'hB6, 8'h05); rd(8'hB6, v); chk("R3 other write aborts", v, 8'h01);
        wr(8'hF7, 8'h55); wr(8'hF7, 8'h55); wr(8'hF7, 8'hAA); wr(8'hF7, 8'h5A);
        wr(8'hB6, 8'h06); rd(8'hB6, v); chk("R3 repeated 55 restarts code", v, 8'h06);
    endtask

    task automatic t_relock();
        logic [7:0] v;
        wr(8'hB6, 8'h07); rd(8'hB6, v); chk("R4 second write locked", v, 8'h06);
        unlock(); wr(8'hF7, 8'h00); wr(8'hB6, 8'h07); rd(8'hB6, v);
        chk("R4 open spent by other write", v, 8'h06);
    endtask

    task automatic t_fields();
        logic [7:0] v;
        unlock(); wr(8'hB6, 8'h7F); rd(8'hB6, v); chk("R5 unused bits zero", v, 8'h2F);
    endtask

    task automatic t_period0();
        logic [7:0] v; int f, h;
        unlock(); wr(8'hB6, 8'h20);
        window(0, 8'h00, 300, f, h);
        chk("R6 period k=0", f, 256);
        chk("R7 pulse width", h, 1);
        rd(8'hB6, v); chk("R10 flag set and kept", v, 8'hA0);
    endtask

    task automatic t_flagclr();
        logic [7:0] v;
        unlock(); wr(8'hB6, 8'hA0); rd(8'hB6, v); chk("R10 write 1 keeps flag", v, 8'hA0);
        unlock(); wr(8'hB6, 8'h20); rd(8'hB6, v); chk("R10 write 0 clears flag", v, 8'h20);
        unlock(); wr(8'hB6, 8'hA0); rd(8'hB6, v); chk("R10 write 1 no set", v, 8'h20);
    endtask

    task automatic t_kick();
        int f, h;
        window(100, 8'h55, 400, f, h); chk("R8 refresh restarts", f, 356);
        window(100, 8'h33, 300, f, h); chk("R8 wrong code ignored", f, 256);
    endtask

    task automatic t_period2();
        int f, h;
        unlock(); wr(8'hB6, 8'h22);
        window(0, 8'h00, 1100, f, h);
        chk("R6 period k=2", f, 1024);
        chk("R7 one pulse k=2", h, 1);
    endtask

    task automatic t_extrst();
        logic [7:0] v;
        ext_rst = 1'b1; @(posedge clk); @(negedge clk); ext_rst = 1'b0;
        rd(8'hB6, v); chk("R11 ext reset clears", v, 8'h04);
    endtask

    task automatic t_freeze();
        int h, h2, f;
        unlock(); wr(8'hB6, 8'h00);
        cfg_en = 1'b1;
        wr(8'hB7, 8'h55);
        idle(100, h);
        cfg_en = 1'b0;
        idle(150, h); wr(8'hB7, 8'h55); idle(150, h2);
        chk("R9 stopped gives no request", h + h2, 0);
        cfg_en = 1'b1; f = 0;
        for (int i = 1; i <= 300; i++) begin
            @(posedge clk); @(negedge clk);
            if (rst_req && f == 0) f = i;
        end
        chk("R9 held count resumes under cfg_en", f, 156);
        cfg_en = 1'b0;
    endtask

    task automatic t_por();
        logic [7:0] v;
        rd(8'hB6, v); chk("R10 flag after forced run", v, 8'h80);
        #1 por_n = 1'b0; #3 por_n = 1'b1;
        @(negedge clk);
        rd(8'hB6, v); chk("R11 power-on clears", v, 8'h04);
    endtask

    initial begin
        por_n = 1'b0; ext_rst = 1'b0; osc_tick = 1'b1; cfg_en = 1'b0;
        bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_seq();
        t_relock();
        t_fields();
        t_period0();
        t_flagclr();
        t_kick();
        t_period2();
        t_extrst();
        t_freeze();
        t_por();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule